// File: doc/BRIEF.md
# Programmable Asynchronous Serial Receiver

This block takes an asynchronous serial line and turns each character on it into a parallel byte for a processor bus. A control register sets the character format: a word length of five to eight data bits, an optional parity bit of even or odd sense, and one or two stop bits. The line is sampled on a 16x sample-enable input, which comes from a baud-rate generator outside the block. A falling edge starts a candidate start bit. The start bit is confirmed at its middle sample. After that, every data, parity and stop bit is sampled at its centre.

The receiver has two stages. A frame engine assembles the character in a shift register. When the frame is complete, the character moves into a holding register, together with its parity and framing verdicts, and waits there for the processor to read it. A status register reports data available, overrun, parity error and framing error. The data-available flag is also driven on its own pin. An interrupt output asserts when interrupts are enabled and either data is waiting or an overrun has happened.

The processor side is a strobed register port, not a stream. A read returns its value in the same cycle and never stalls. A write always takes effect. No back-pressure reaches the serial line. A character that arrives while the holding register is still full is the only case where data is refused, and that case is reported as an overrun.

Top module: `sio_rx_top`

## Requirements
- R1: After reset the status register reads 0, `data_avail` and `irq` are 0, and the format is 8 data bits, no parity, one stop bit (control value 0x03).
- R2: A low on the line counts as a start bit only if the line is still low at the eighth sample after the falling edge. A shorter low pulse leaves the receiver idle, and no character and no status change results.
- R3: Data bits are taken LSB first. Control bits [1:0] select 5+code data bits. Holding-register bits at or above the word length read as 0.
- R4: Control bit 2 enables a parity bit and control bit 3 selects odd parity (0 selects even). A parity mismatch sets status bit 2, which is stored with the character.
- R5: A low stop-bit sample sets status bit 3, which is stored with the character. With control bit 4 set, two stop bits are expected and a low sample in either one sets the flag.
- R6: When a character completes, `data_avail` and status bit 0 go to 1. A read of the data register (chip select, read strobe, register select 0) clears them on the next edge.
- R7: If a character completes while the previous one is still unread, status bit 1 (overrun) is set, the new character is dropped, and the held character and its flags are kept. A data-register read clears the overrun flag.
- R8: If a data-register read falls in the same cycle as a character completion, the read returns the old character, the new character is loaded, `data_avail` stays 1 and no overrun is flagged.
- R9: `irq` equals control bit 5 AND (data available OR overrun).
- R10: `rdata` is 0 whenever chip select and read are not both high. Register select 1 reads the status register, and a write with chip select and register select 1 loads the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | 16x oversampling enable, one pulse per sample |
| rxd | input | 1 | Serial receive line, idle high |
| cs | input | 1 | Chip select |
| rsel | input | 1 | Register select: 0 data, 1 status (read) / control (write) |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data for the control register |
| rdata | output | 8 | Read data, 0 when not reading |
| data_avail | output | 1 | Holding register contains an unread character |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can land on the same clock edge: a character completing in the frame engine, and the processor reading the data register. The bench runs the sample enable at one pulse per cycle, so the cycle in which a frame finishes can be worked out from the bit count. It sends a first character and leaves it unread. It then sends a second character and issues a single-cycle data read timed to coincide with the second character's completion. The read must return the first character. After that edge, the second character must be held with data available still set and no overrun. A separate case places the second completion before any read, and there the overrun path must win instead.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;

  localparam int DATA_W = 8;

  // control register layout, MSB first
  typedef struct packed {
    logic       irq_en;
    logic       two_stop;
    logic       odd_par;
    logic       par_en;
    logic [1:0] wlen;
  } rx_cfg_t;

  localparam int CFG_W = $bits(rx_cfg_t);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } rx_state_e;

endpackage

// File: rtl/sio_rx_frame.sv
module sio_rx_frame
  import sio_rx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DW    = DATA_W,
  parameter int SYNC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  rx_cfg_t       cfg,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          perr,
  output logic          ferr
);

  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DW);
  localparam logic [CW-1:0] MID_CNT = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] END_CNT = CW'(OSR - 1);

  // input synchronizer
  logic [SYNC:0] sync_q;
  assign sync_q[0] = rxd;
  for (genvar g = 0; g < SYNC; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g+1] <= 1'b1;
      else        sync_q[g+1] <= sync_q[g];
    end
  end
  logic line;
  assign line = sync_q[SYNC];

  rx_state_e       st;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bidx;
  logic            par_acc;
  logic [BW-1:0]   last_idx;

  assign last_idx = BW'(cfg.wlen) + BW'(DW - 4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      par_acc <= 1'b0;
      data    <= '0;
      perr    <= 1'b0;
      ferr    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (st)
          ST_IDLE: begin
            if (!line) begin
              st  <= ST_START;
              cnt <= '0;
            end
          end
          ST_START: begin
            if (cnt == MID_CNT) begin
              cnt <= '0;
              if (!line) begin
                st      <= ST_DATA;
                bidx    <= '0;
                par_acc <= 1'b0;
                data    <= '0;
                perr    <= 1'b0;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt == END_CNT) begin
              cnt        <= '0;
              data[bidx] <= line;
              par_acc    <= par_acc ^ line;
              if (bidx == last_idx) st <= cfg.par_en ? ST_PAR : ST_STOP1;
              else                  bidx <= bidx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (cnt == END_CNT) begin
              cnt  <= '0;
              perr <= (par_acc ^ line) != cfg.odd_par;
              st   <= ST_STOP1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP1: begin
            if (cnt == END_CNT) begin
              cnt  <= '0;
              ferr <= !line;
              if (cfg.two_stop) begin
                st <= ST_STOP2;
              end else begin
                st   <= ST_IDLE;
                done <= 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP2: begin
            if (cnt == END_CNT) begin
              cnt  <= '0;
              ferr <= ferr | !line;
              st   <= ST_IDLE;
              done <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/sio_rx_hold.sv
module sio_rx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic [DW-1:0] din,
  input  logic          pe_in,
  input  logic          fe_in,
  input  logic          rd_data,
  output logic [DW-1:0] hold_q,
  output logic          da_q,
  output logic          ovr_q,
  output logic          pe_q,
  output logic          fe_q
);

  // a read in the completion cycle frees the slot first
  logic slot_free;
  assign slot_free = !da_q || rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      da_q   <= 1'b0;
      ovr_q  <= 1'b0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
    end else begin
      if (done && slot_free) begin
        hold_q <= din;
        pe_q   <= pe_in;
        fe_q   <= fe_in;
        da_q   <= 1'b1;
      end else if (rd_data) begin
        da_q <= 1'b0;
      end

      if (done && !slot_free) ovr_q <= 1'b1;
      else if (rd_data)       ovr_q <= 1'b0;
    end
  end

endmodule

// File: rtl/sio_rx_bus.sv
module sio_rx_bus
  import sio_rx_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter logic [CFG_W-1:0] CFG_RST = CFG_W'(6'h03)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          rsel,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] hold_q,
  input  logic          da_q,
  input  logic          ovr_q,
  input  logic          pe_q,
  input  logic          fe_q,
  output rx_cfg_t       cfg,
  output logic          rd_data,
  output logic [DW-1:0] rdata,
  output logic          irq
);

  logic [DW-1:0] status;
  assign status  = DW'({fe_q, pe_q, ovr_q, da_q});
  assign rd_data = cs && rd && !rsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cfg <= rx_cfg_t'(CFG_RST);
    else if (cs && wr && rsel) cfg <= rx_cfg_t'(wdata[CFG_W-1:0]);
  end

  always_comb begin
    if (cs && rd) rdata = rsel ? status : hold_q;
    else          rdata = '0;
  end

  assign irq = cfg.irq_en && (da_q || ovr_q);

endmodule

// File: rtl/sio_rx_top.sv
module sio_rx_top
  import sio_rx_pkg::*;
#(
  parameter int OSR  = 16,
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic              rxd,
  input  logic              cs,
  input  logic              rsel,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              data_avail,
  output logic              irq
);

  rx_cfg_t           cfg;
  logic              frm_done;
  logic [DATA_W-1:0] frm_data;
  logic              frm_pe;
  logic              frm_fe;
  logic [DATA_W-1:0] hold_data;
  logic              st_da;
  logic              st_ovr;
  logic              st_pe;
  logic              st_fe;
  logic              rd_data;

  sio_rx_frame #(.OSR(OSR), .DW(DATA_W), .SYNC(SYNC)) u_frame (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (sample_en),
    .rxd  (rxd),
    .cfg  (cfg),
    .done (frm_done),
    .data (frm_data),
    .perr (frm_pe),
    .ferr (frm_fe)
  );

  sio_rx_hold #(.DW(DATA_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (frm_done),
    .din    (frm_data),
    .pe_in  (frm_pe),
    .fe_in  (frm_fe),
    .rd_data(rd_data),
    .hold_q (hold_data),
    .da_q   (st_da),
    .ovr_q  (st_ovr),
    .pe_q   (st_pe),
    .fe_q   (st_fe)
  );

  sio_rx_bus #(.DW(DATA_W)) u_bus (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs     (cs),
    .rsel   (rsel),
    .rd     (rd),
    .wr     (wr),
    .wdata  (wdata),
    .hold_q (hold_data),
    .da_q   (st_da),
    .ovr_q  (st_ovr),
    .pe_q   (st_pe),
    .fe_q   (st_fe),
    .cfg    (cfg),
    .rd_data(rd_data),
    .rdata  (rdata),
    .irq    (irq)
  );

  assign data_avail = st_da;

endmodule

// File: rtl/sio_rx_top_chk.sv
module sio_rx_top_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          rd,
  input logic          rsel,
  input logic [DW-1:0] rdata,
  input logic          data_avail,
  input logic          irq,
  input logic          done,
  input logic          ovr,
  input logic [DW-1:0] hold
);

  logic data_read;
  assign data_read = cs && rd && !rsel;

  // R6
  read_clears_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_read && !done) |=> !data_avail);

  // R7
  overrun_keeps_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && data_avail && !data_read) |=> (ovr && $stable(hold)));

  // R8
  read_wins_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && data_read) |=> (data_avail && !ovr));

  // R9
  irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (data_avail || ovr));

  // R10
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd) |-> (rdata == '0));

endmodule

bind sio_rx_top sio_rx_top_chk #(.DW(8)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs        (cs),
  .rd        (rd),
  .rsel      (rsel),
  .rdata     (rdata),
  .data_avail(data_avail),
  .irq       (irq),
  .done      (frm_done),
  .ovr       (st_ovr),
  .hold      (hold_data)
);

// File: tb/sio_rx_top_test.sv
module sio_rx_top_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_en = 1'b1;
  logic       rxd = 1'b1;
  logic       cs = 1'b0;
  logic       rsel = 1'b0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       data_avail;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int div = 1;
  int tcnt = 0;
  bit finished = 0;

  sio_rx_top uut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rxd(rxd),
    .cs(cs), .rsel(rsel), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rdata), .data_avail(data_avail), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (tcnt >= div - 1) begin
      tcnt = 0;
      sample_en <= 1'b1;
    end else begin
      tcnt = tcnt + 1;
      sample_en <= 1'b0;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_read(input logic sel, output logic [7:0] val);
    @(negedge clk);
    cs = 1; rd = 1; rsel = sel;
    #1 val = rdata;
    @(negedge clk);
    cs = 0; rd = 0; rsel = 0;
  endtask

  task automatic bus_write(input logic [7:0] val);
    @(negedge clk);
    cs = 1; wr = 1; rsel = 1; wdata = val;
    @(negedge clk);
    cs = 0; wr = 0; rsel = 0;
  endtask

  function automatic logic [7:0] word_mask(input logic [7:0] cfg);
    return 8'hFF >> (3 - cfg[1:0]);
  endfunction

  function automatic logic [7:0] exp_status(input bit da, input bit ov, input bit pe, input bit fe);
    return {4'b0, fe, pe, ov, da};
  endfunction

  task automatic bit_out(input logic v);
    rxd = v;
    repeat (16 * div) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] cfg, input logic [7:0] d,
                      input bit bad_par, input bit bad_stop);
    int n;
    logic [7:0] m;
    m = d & word_mask(cfg);
    n = 5 + cfg[1:0];
    @(negedge clk);
    bit_out(1'b0);
    for (int i = 0; i < n; i++) bit_out(m[i]);
    if (cfg[2]) bit_out((^m) ^ cfg[3] ^ bad_par);
    if (cfg[4]) bit_out(1'b1);
    bit_out(!bad_stop);
    rxd = 1'b1;
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] cfg;
    logic [7:0] d;
    bit bp, bs;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 data_avail", {7'b0, data_avail}, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    bus_read(1'b1, v);
    check("R1 status", v, 8'h00);
    // R10 idle bus
    #1 check("R10 idle rdata", rdata, 8'h00);

    // R1 default 8N1 format
    send(8'h03, 8'hA5, 0, 0);
    repeat (20) @(negedge clk);
    bus_read(1'b1, v);
    check("R1 default format status", v, exp_status(1, 0, 0, 0));
    bus_read(1'b0, v);
    check("R1 default format data", v, 8'hA5);
    // R6 cleared by read
    check("R6 pin cleared", {7'b0, data_avail}, 8'h00);
    bus_read(1'b1, v);
    check("R6 status cleared", v, exp_status(0, 0, 0, 0));

    // R2 short low pulse
    @(negedge clk);
    rxd = 0;
    repeat (6) @(negedge clk);
    rxd = 1;
    repeat (60) @(negedge clk);
    check("R2 no char pin", {7'b0, data_avail}, 8'h00);
    bus_read(1'b1, v);
    check("R2 status", v, 8'h00);

    // R3 five-bit word, upper bits zero
    bus_write(8'h00);
    send(8'h00, 8'hFF, 0, 0);
    repeat (20) @(negedge clk);
    bus_read(1'b0, v);
    check("R3 five-bit data", v, 8'h1F);

    // R7 overrun
    bus_write(8'h03);
    send(8'h03, 8'h3C, 0, 0);
    send(8'h03, 8'hC3, 0, 0);
    repeat (20) @(negedge clk);
    bus_read(1'b1, v);
    check("R7 overrun status", v, exp_status(1, 1, 0, 0));
    bus_read(1'b0, v);
    check("R7 old char kept", v, 8'h3C);
    bus_read(1'b1, v);
    check("R7 overrun cleared", v, exp_status(0, 0, 0, 0));

    // R8 read coinciding with completion (div 1, 8N1: stop index 8)
    send(8'h03, 8'h11, 0, 0);
    repeat (20) @(negedge clk);
    fork
      send(8'h03, 8'h22, 0, 0);
      begin
        repeat (28 + 16 * 8) @(negedge clk);
        cs = 1; rd = 1; rsel = 0;
        #1 check("R8 read returns old", rdata, 8'h11);
        @(negedge clk);
        cs = 0; rd = 0;
      end
    join
    repeat (20) @(negedge clk);
    bus_read(1'b1, v);
    check("R8 status after collision", v, exp_status(1, 0, 0, 0));
    bus_read(1'b0, v);
    check("R8 new char loaded", v, 8'h22);

    // R9 interrupt
    bus_write(8'h23);
    send(8'h23, 8'h5A, 0, 0);
    repeat (20) @(negedge clk);
    check("R9 irq on data", {7'b0, irq}, 8'h01);
    bus_read(1'b0, v);
    check("R9 irq cleared", {7'b0, irq}, 8'h00);

    // R5 two stop bits, second low
    bus_write(8'h13);
    send(8'h13, 8'h81, 0, 1);
    repeat (40) @(negedge clk);
    bus_read(1'b1, v);
    check("R5 second stop framing", v, exp_status(1, 0, 0, 1));
    bus_read(1'b0, v);
    check("R5 data with framing", v, 8'h81);

    // random frames: R3 R4 R5 R6 R9
    void'($urandom(32'h1357));
    for (int k = 0; k < 40; k++) begin
      cfg = {2'b00, 6'($urandom) & 6'h1F};
      d = 8'($urandom);
      bp = cfg[2] && ($urandom % 5 == 0);
      bs = ($urandom % 5 == 0);
      div = 1 + ($urandom % 3);
      bus_write(cfg);
      send(cfg, d, bp, bs);
      repeat (16 * div + 4) @(negedge clk);
      check("R6 random pin", {7'b0, data_avail}, 8'h01);
      check("R9 random irq off", {7'b0, irq}, 8'h00);
      bus_read(1'b1, v);
      check("R4 R5 random status", v, exp_status(1, 0, bp, bs));
      bus_read(1'b0, v);
      check("R3 random data", v, d & word_mask(cfg));
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule